// File: doc/BRIEF.md
# Touch ADC channel acquisition sequencer

This block runs a complete acquisition scan against a resistive-touch analog converter through its own mode-0 SPI master pins. A single start pulse captures an 8-bit channel mask and, for every channel, a settle-frame count and an oversample count. Channels in the mask are visited from the lowest index upward. Each channel gets a back-to-back run of 24-bit frames. A frame is an 8-bit command byte followed by a 16-bit response word. The whole scan sits inside one chip-select assertion.

For each channel, the responses from the leading settling frames are dropped. The remaining 12-bit samples are summed and divided by their number, with the quotient rounded up. The averaged values are packed into result slots in the order the channels were visited. When the last enabled channel has been averaged, chip select is released, a one-cycle valid strobe is issued and a done flag rises. The done flag stays high until the next accepted start. Converting settling time into frame counts is left to the caller.

Top module: `touch_scan_seq`

## Requirements
- R1: Each command byte carries, from MSB down: start bit 7 = 1, channel address in bits 6:4, bit 3 = 0 (12-bit conversion), then the single-ended flag in bit 2 and reference-on in bit 1. Bits 2 and 1 are both 1 for addresses 0, 2, 6 and 7, and both 0 for addresses 1, 3, 4 and 5.
- R2: Bit 0 (converter-on) is 1 in every frame of a channel's run except the last frame, where it is 0.
- R3: A channel's run has settle + max(oversample, 1) frames; an oversample count of 0 counts as 1. The responses of the first settle frames are excluded from the result.
- R4: A sample is bits 14:3 of the 16-bit response word, sent MSB first. A result is ceil(sum of kept samples / number kept). Up to 255 kept 12-bit samples are averaged without overflow.
- R5: Enabled channels are scanned in ascending index. The k-th scanned channel's result goes to slot k (bits 16k+15:16k of res_data). Slots beyond the number of enabled channels read 0.
- R6: Chip select goes low once per non-empty scan and stays low from the first frame to the last. It is high whenever no scan runs.
- R7: The SPI uses mode 0: sclk idles low, MOSI changes only while sclk is low, and MISO is sampled on the rising edge of sclk.
- R8: At scan end res_valid is high for exactly one cycle, and done rises with it. done then stays high until a new scan is accepted.
- R9: A start with an all-zero mask ends the scan with no chip-select assertion, with all slots 0 and with the res_valid/done behaviour of R8.
- R10: A start pulse while a scan is running is ignored: that scan's results, frame count and single res_valid pulse are unchanged.
- R11: After reset spi_cs_n = 1, spi_sclk = 0, res_valid = 0, done = 0 and all slots read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle scan request |
| chan_mask | input | 8 | Channel enable mask, bit i enables address i |
| settle_cnt | input | 64 | Settling frames per channel, 8 bits each, channel i at bits 8i+7:8i |
| ovs_cnt | input | 64 | Oversample frames per channel, 8 bits each, 0 treated as 1 |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_mosi | output | 1 | SPI data to converter |
| spi_miso | input | 1 | SPI data from converter |
| spi_cs_n | output | 1 | Active-low chip select |
| res_data | output | 128 | Eight 16-bit averaged results in scan order |
| res_valid | output | 1 | One-cycle strobe at scan end |
| done | output | 1 | Scan complete flag |

## Verification
On every cycle, assertions hold the SPI clock low between frames, keep MOSI steady while the clock is high and keep chip select low through every frame. They also bound the frame index by the run length, check that each quotient is the exact rounded-up ratio of its operands, and keep the valid strobe to a single cycle. The bench alone can show the behaviours seen across a whole scan. These are the command byte sequence and its power-down frame, which responses are dropped, the channel order and slot packing, and that a start is ignored during a scan. The bench checks them by sweeping masks and count combinations against a converter model whose sample value changes every frame.

// File: rtl/touch_seq_pkg.sv
package touch_seq_pkg;
  localparam int FRAME_BITS = 24;
  localparam int CMD_BITS   = 8;
  localparam int ADC_BITS   = 12;
  localparam int ADC_LSB    = 3;
  localparam int ADDR_W     = 3;

  // Command byte: start, address, 12-bit mode, single-ended, ref-on, converter-on
  function automatic logic [CMD_BITS-1:0] build_cmd(input logic [ADDR_W-1:0] addr,
                                                    input logic keep_on);
    logic se;
    se = (addr == 3'd0) || (addr == 3'd2) || (addr == 3'd6) || (addr == 3'd7);
    return {1'b1, addr, 1'b0, se, se, keep_on};
  endfunction
endpackage

// File: rtl/touch_spi_frame.sv
module touch_spi_frame
  import touch_seq_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                go,
  input  logic [CMD_BITS-1:0] cmd_i,
  input  logic                miso,
  output logic                sclk,
  output logic                mosi,
  output logic                busy,
  output logic                frame_done,
  output logic [15:0]         rx_word
);
  localparam int HW  = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BCW = $clog2(FRAME_BITS);

  logic [HW-1:0]         half_cnt;
  logic [BCW-1:0]        bit_cnt;
  logic [FRAME_BITS-1:0] tx_sr;
  logic [FRAME_BITS-1:0] rx_sr;

  assign mosi = busy ? tx_sr[FRAME_BITS-1] : 1'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      sclk       <= 1'b0;
      half_cnt   <= '0;
      bit_cnt    <= '0;
      tx_sr      <= '0;
      rx_sr      <= '0;
      frame_done <= 1'b0;
      rx_word    <= '0;
    end else begin
      frame_done <= 1'b0;
      if (!busy) begin
        if (go) begin
          busy     <= 1'b1;
          sclk     <= 1'b0;
          half_cnt <= '0;
          bit_cnt  <= '0;
          tx_sr    <= {cmd_i, {(FRAME_BITS-CMD_BITS){1'b0}}};
        end
      end else if (half_cnt == HW'(HALF_DIV-1)) begin
        half_cnt <= '0;
        if (!sclk) begin
          sclk  <= 1'b1;
          rx_sr <= {rx_sr[FRAME_BITS-2:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bit_cnt == BCW'(FRAME_BITS-1)) begin
            busy       <= 1'b0;
            frame_done <= 1'b1;
            rx_word    <= rx_sr[15:0];
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
            tx_sr   <= {tx_sr[FRAME_BITS-2:0], 1'b0};
          end
        end
      end else begin
        half_cnt <= half_cnt + 1'b1;
      end
    end
  end

  // R7: clock idles low between frames
  a_r7_sclk_idle_low: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sclk);
  // R7: data line holds while the clock is high
  a_r7_mosi_stable_high: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(mosi));
endmodule

// File: rtl/touch_ceil_div.sv
module touch_ceil_div #(
  parameter int NUM_W = 20,
  parameter int DEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W:0]   quo
);
  localparam int QW = NUM_W + 1;
  localparam int CW = $clog2(QW + 1);

  logic [QW-1:0]    work;
  logic [DEN_W-1:0] rem;
  logic [DEN_W-1:0] den_q;
  logic [NUM_W-1:0] num_q;
  logic [CW-1:0]    steps;
  logic [DEN_W:0]   partial;

  assign partial = {rem, work[QW-1]};
  assign quo     = work;

  always_ff @(posedge clk) begin
    if (rst) begin
      work  <= '0;
      rem   <= '0;
      den_q <= '0;
      num_q <= '0;
      steps <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        // ceil(a/b) = floor((a + b - 1) / b)
        work  <= QW'(num) + QW'(den) - QW'(1);
        rem   <= '0;
        den_q <= den;
        num_q <= num;
        steps <= CW'(QW);
      end else if (steps != '0) begin
        steps <= steps - 1'b1;
        if (partial >= {1'b0, den_q}) begin
          rem  <= DEN_W'(partial - {1'b0, den_q});
          work <= {work[QW-2:0], 1'b1};
        end else begin
          rem  <= partial[DEN_W-1:0];
          work <= {work[QW-2:0], 1'b0};
        end
        if (steps == CW'(1)) done <= 1'b1;
      end
    end
  end

  // R4: quotient is the exact rounded-up ratio
  a_r4_ceil_quotient: assert property (@(posedge clk) disable iff (rst)
    done |-> ((40'(quo) * 40'(den_q) >= 40'(num_q)) &&
              (40'(quo) * 40'(den_q) <  40'(num_q) + 40'(den_q))));
endmodule

// File: rtl/touch_scan_seq.sv
module touch_scan_seq
  import touch_seq_pkg::*;
#(
  parameter int N_CH     = 8,
  parameter int CNT_W    = 8,
  parameter int RES_W    = 16,
  parameter int HALF_DIV = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [N_CH-1:0]        chan_mask,
  input  logic [N_CH*CNT_W-1:0]  settle_cnt,
  input  logic [N_CH*CNT_W-1:0]  ovs_cnt,
  output logic                   spi_sclk,
  output logic                   spi_mosi,
  input  logic                   spi_miso,
  output logic                   spi_cs_n,
  output logic [N_CH*RES_W-1:0]  res_data,
  output logic                   res_valid,
  output logic                   done
);
  localparam int CH_W  = $clog2(N_CH);
  localparam int SUM_W = ADC_BITS + CNT_W;
  localparam int RUN_W = CNT_W + 1;

  typedef enum logic [2:0] {S_IDLE, S_NEXT, S_FRAME, S_WAIT, S_DIV, S_DIVW} seq_state_t;
  seq_state_t state;

  logic [N_CH-1:0]  mask_q;
  logic [CNT_W-1:0] settle_q [N_CH];
  logic [CNT_W-1:0] ovs_q    [N_CH];
  logic [RES_W-1:0] res_q    [N_CH];

  logic [CH_W:0]    ch_ptr;
  logic [CH_W-1:0]  cur_ch;
  logic [CH_W:0]    slot;
  logic [RUN_W-1:0] run_len;
  logic [RUN_W-1:0] frame_idx;
  logic [CNT_W-1:0] settle_cur;
  logic [CNT_W-1:0] keep_cur;
  logic [SUM_W-1:0] acc;

  logic [CH_W:0]    next_ch;
  logic             fr_go, fr_busy, fr_done;
  logic [15:0]      fr_rx;
  logic [CMD_BITS-1:0] fr_cmd;
  logic             div_start, div_done;
  logic [SUM_W:0]   div_quo;
  logic             last_frame;

  function automatic logic [CH_W:0] find_next(input logic [N_CH-1:0] m,
                                              input logic [CH_W:0] from);
    logic [CH_W:0] r;
    r = (CH_W+1)'(N_CH);
    for (int i = N_CH - 1; i >= 0; i--)
      if (m[i] && ((CH_W+1)'(i) >= from)) r = (CH_W+1)'(i);
    return r;
  endfunction

  assign next_ch    = find_next(mask_q, ch_ptr);
  assign last_frame = (frame_idx == run_len - RUN_W'(1));
  assign fr_go      = (state == S_FRAME);
  assign fr_cmd     = build_cmd(ADDR_W'(cur_ch), !last_frame);
  assign div_start  = (state == S_DIV);

  generate
    for (genvar g = 0; g < N_CH; g++) begin : g_slot
      assign res_data[g*RES_W +: RES_W] = res_q[g];
    end
  endgenerate

  touch_spi_frame #(.HALF_DIV(HALF_DIV)) u_frame (
    .clk        (clk),
    .rst        (rst),
    .go         (fr_go),
    .cmd_i      (fr_cmd),
    .miso       (spi_miso),
    .sclk       (spi_sclk),
    .mosi       (spi_mosi),
    .busy       (fr_busy),
    .frame_done (fr_done),
    .rx_word    (fr_rx)
  );

  touch_ceil_div #(.NUM_W(SUM_W), .DEN_W(CNT_W)) u_div (
    .clk   (clk),
    .rst   (rst),
    .start (div_start),
    .num   (acc),
    .den   (keep_cur),
    .done  (div_done),
    .quo   (div_quo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      mask_q     <= '0;
      ch_ptr     <= '0;
      cur_ch     <= '0;
      slot       <= '0;
      run_len    <= '0;
      frame_idx  <= '0;
      settle_cur <= '0;
      keep_cur   <= '0;
      acc        <= '0;
      spi_cs_n   <= 1'b1;
      res_valid  <= 1'b0;
      done       <= 1'b0;
      for (int i = 0; i < N_CH; i++) begin
        settle_q[i] <= '0;
        ovs_q[i]    <= '0;
        res_q[i]    <= '0;
      end
    end else begin
      res_valid <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          mask_q <= chan_mask;
          ch_ptr <= '0;
          slot   <= '0;
          done   <= 1'b0;
          for (int i = 0; i < N_CH; i++) begin
            settle_q[i] <= settle_cnt[i*CNT_W +: CNT_W];
            ovs_q[i]    <= ovs_cnt[i*CNT_W +: CNT_W];
            res_q[i]    <= '0;
          end
          state <= S_NEXT;
        end
        S_NEXT: begin
          if (next_ch == (CH_W+1)'(N_CH)) begin
            spi_cs_n  <= 1'b1;
            res_valid <= 1'b1;
            done      <= 1'b1;
            state     <= S_IDLE;
          end else begin
            cur_ch     <= next_ch[CH_W-1:0];
            settle_cur <= settle_q[next_ch[CH_W-1:0]];
            if (ovs_q[next_ch[CH_W-1:0]] == '0) begin
              keep_cur <= CNT_W'(1);
              run_len  <= RUN_W'(settle_q[next_ch[CH_W-1:0]]) + RUN_W'(1);
            end else begin
              keep_cur <= ovs_q[next_ch[CH_W-1:0]];
              run_len  <= RUN_W'(settle_q[next_ch[CH_W-1:0]]) +
                          RUN_W'(ovs_q[next_ch[CH_W-1:0]]);
            end
            frame_idx <= '0;
            acc       <= '0;
            spi_cs_n  <= 1'b0;
            state     <= S_FRAME;
          end
        end
        S_FRAME: state <= S_WAIT;
        S_WAIT: if (fr_done) begin
          if (frame_idx >= RUN_W'(settle_cur))
            acc <= acc + SUM_W'(fr_rx[ADC_LSB +: ADC_BITS]);
          if (last_frame) begin
            state <= S_DIV;
          end else begin
            frame_idx <= frame_idx + 1'b1;
            state     <= S_FRAME;
          end
        end
        S_DIV: state <= S_DIVW;
        S_DIVW: if (div_done) begin
          res_q[slot[CH_W-1:0]] <= div_quo[RES_W-1:0];
          slot   <= slot + 1'b1;
          ch_ptr <= (CH_W+1)'(cur_ch) + 1'b1;
          state  <= S_NEXT;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R3: frame index never leaves the run
  a_r3_frame_in_run: assert property (@(posedge clk) disable iff (rst)
    (state == S_WAIT) |-> (frame_idx < run_len));
  // R6: chip select low during every frame
  a_r6_cs_low_in_frame: assert property (@(posedge clk) disable iff (rst)
    fr_busy |-> !spi_cs_n);
  // R6: chip select high while idle
  a_r6_cs_high_idle: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE) |-> spi_cs_n);
  // R8: valid is a single-cycle strobe accompanied by done
  a_r8_valid_single: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);
  a_r8_valid_with_done: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> done);
  // R5: never more slots than channels
  a_r5_slot_bound: assert property (@(posedge clk) disable iff (rst)
    slot <= (CH_W+1)'(N_CH));
endmodule

// File: tb/touch_scan_seq_tb.sv
module touch_scan_seq_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [7:0] chan_mask = '0;
  logic [63:0] settle_cnt = '0;
  logic [63:0] ovs_cnt = '0;
  logic spi_sclk, spi_mosi, spi_cs_n, res_valid, done;
  logic spi_miso = 1'b0;
  logic [127:0] res_data;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  touch_scan_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .chan_mask(chan_mask),
    .settle_cnt(settle_cnt), .ovs_cnt(ovs_cnt),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n), .res_data(res_data), .res_valid(res_valid), .done(done)
  );

  // ---------------- converter model ----------------
  int   mbit = 0;
  int   gframe = 0;
  int   ncmd = 0;
  int   cs_falls = 0;
  int   valid_pulses = 0;
  logic [7:0]  cmd_sr = '0;
  logic [7:0]  cmd_log [0:1023];
  logic [23:0] resp = '0;

  function automatic int sample_val(int addr, int g);
    return (addr * 512 + g * 97 + 13) % 4096;
  endfunction

  always @(negedge spi_cs_n or posedge spi_sclk) begin
    if (!spi_sclk) begin
      mbit = 0;
      gframe = 0;
      cs_falls++;
    end else if (!spi_cs_n) begin
      if (mbit < 8) cmd_sr = {cmd_sr[6:0], spi_mosi};
      if (mbit == 7) begin
        if (ncmd < 1024) cmd_log[ncmd] = cmd_sr;
        ncmd++;
        resp = {8'h00, 1'b0, 12'(sample_val(int'(cmd_sr[6:4]), gframe)), 3'b000};
        gframe++;
      end
      mbit = (mbit == 23) ? 0 : mbit + 1;
    end
  end

  always @(negedge spi_sclk) begin
    if (!spi_cs_n && mbit >= 8) spi_miso = resp[23 - mbit];
    else spi_miso = 1'b0;
  end

  always @(posedge clk) if (res_valid) valid_pulses++;

  // ---------------- helpers ----------------
  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic run_scan(input logic [7:0] m, input int s[8], input int o[8],
                          input bit restart_mid);
    int exp_res[8];
    logic [7:0] exp_cmd [0:1023];
    int nexp, slot, g, k, n, sum, l, bad, badidx, waitc;
    logic se;
    // expected values
    nexp = 0; slot = 0; g = 0;
    for (int i = 0; i < 8; i++) exp_res[i] = 0;
    for (int c = 0; c < 8; c++) begin
      if (m[c]) begin
        n = (o[c] == 0) ? 1 : o[c];
        l = s[c] + n;
        sum = 0;
        se = (c == 0) || (c == 2) || (c == 6) || (c == 7);
        for (int f = 0; f < l; f++) begin
          if (f >= s[c]) sum += sample_val(c, g);
          exp_cmd[nexp] = {1'b1, 3'(c), 1'b0, se, se, (f != l - 1)};
          nexp++;
          g++;
        end
        exp_res[slot] = (sum + n - 1) / n;
        slot++;
      end
    end
    // drive
    @(negedge clk);
    chan_mask = m;
    for (int c = 0; c < 8; c++) begin
      settle_cnt[c*8 +: 8] = 8'(s[c]);
      ovs_cnt[c*8 +: 8] = 8'(o[c]);
    end
    ncmd = 0; cs_falls = 0; valid_pulses = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (restart_mid) begin
      repeat (40) @(negedge clk);
      chan_mask = ~m;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    waitc = 0;
    while (!done && waitc < 60000) begin
      @(negedge clk);
      waitc++;
    end
    repeat (5) @(negedge clk);
    check(done == 1'b1, "R8", "done after scan", done, 1);
    check(valid_pulses == 1, restart_mid ? "R10" : "R8", "valid pulses", valid_pulses, 1);
    check(spi_cs_n == 1'b1, "R6", "cs released", spi_cs_n, 1);
    check(cs_falls == ((m != 0) ? 1 : 0), (m != 0) ? "R6" : "R9", "cs assertions",
          cs_falls, (m != 0) ? 1 : 0);
    check(ncmd == nexp, "R3", "frame count", ncmd, nexp);
    bad = 0; badidx = 0;
    for (int i = 0; i < nexp && i < ncmd; i++)
      if (cmd_log[i] !== exp_cmd[i]) begin
        if (bad == 0) badidx = i;
        bad++;
      end
    check(bad == 0, "R1/R2", "command byte", (bad == 0) ? 0 : cmd_log[badidx],
          (bad == 0) ? 0 : exp_cmd[badidx]);
    for (k = 0; k < 8; k++)
      check(res_data[k*16 +: 16] == 16'(exp_res[k]), "R4/R5", $sformatf("slot %0d", k),
            res_data[k*16 +: 16], exp_res[k]);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  // ---------------- stimulus ----------------
  initial begin
    int s[8];
    int o[8];
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check(spi_cs_n == 1'b1, "R11", "cs_n after reset", spi_cs_n, 1);
    check(spi_sclk == 1'b0, "R11", "sclk after reset", spi_sclk, 0);
    check(res_valid == 1'b0, "R11", "valid after reset", res_valid, 0);
    check(done == 1'b0, "R11", "done after reset", done, 0);
    check(res_data == '0, "R11", "results after reset", (res_data == '0) ? 0 : 1, 0);

    // single channel, default counts (settle 1, oversample 1)
    for (int c = 0; c < 8; c++) begin s[c] = 1; o[c] = 1; end
    run_scan(8'h20, s, o, 0);
    // all channels: exercise every command encoding (R1)
    run_scan(8'hFF, s, o, 0);
    // R3: no settling, oversample 0 treated as 1
    for (int c = 0; c < 8; c++) begin s[c] = 0; o[c] = 0; end
    run_scan(8'h81, s, o, 0);
    // R9: empty mask
    run_scan(8'h00, s, o, 0);
    // sweep of masks with varied per-channel counts (R3, R4, R5)
    for (int m = 1; m < 256; m += 23) begin
      for (int c = 0; c < 8; c++) begin
        s[c] = (c + m) % 4;
        o[c] = (c * 3 + m) % 5;
      end
      run_scan(8'(m), s, o, 0);
    end
    // R4: 255 kept samples on one channel
    for (int c = 0; c < 8; c++) begin s[c] = 0; o[c] = 1; end
    o[3] = 255; s[3] = 2;
    run_scan(8'h08, s, o, 0);
    // R10: start during a scan is ignored
    for (int c = 0; c < 8; c++) begin s[c] = 2; o[c] = 3; end
    run_scan(8'h5A, s, o, 1);
    finish_run();
  end
endmodule